// File: doc/BRIEF.md
# SD Card Data Buffer with Transfer Gating

This block sits between a host register port and the engine that drives the SD card data lines. It stores 32-bit words in a first-word-fall-through buffer. It tells each side when it may move data, and it counts words against a programmed block size and block count. The direction is fixed for each transfer. In a card-to-host transfer the card engine pushes words and the host pops them. In a host-to-card transfer the host pushes words and the card engine pops them. In both directions the host uses one data port for its side.

The host gets two programmable thresholds. The receive threshold decides when the host may drain a burst. The transmit threshold decides when the card engine may start sending a block. A tail rule overrides either threshold: when the buffer already holds every remaining word of the current block, the transfer may go ahead. Dropped pushes and empty pops raise a sticky error bit. The end of the last block raises a sticky completion bit. A debug word shows the fill level and both thresholds.

Top module: `sd_data_fifo`

## Requirements
- R1: After reset the fill level is 0, status_o is 0, and host_ready_o and card_start_o are both 0. The direction resets to host-to-card.
- R2: debug_o shows the fill level in bits 8:4, the transmit threshold in bits 13:9 and the receive threshold in bits 18:14. All other bits of debug_o are 0.
- R3: The buffer holds 16 words and returns them in push order. The head word is visible on host_rdata_o and card_rdata_o without a pop. An accepted push or pop changes the fill level at the clock edge that accepts it.
- R4: A pulse on xfer_start_i latches the direction (dir_read_i=1 means card-to-host). In card-to-host mode, card_push_i writes and host_rd_i reads. In host-to-card mode, host_wr_i writes and card_pop_i reads. The strobes of the unused pair have no effect.
- R5: A push into a full buffer is dropped and sets status_o bit 3, unless a pop is accepted in the same cycle.
- R6: A pop from an empty buffer leaves the fill level unchanged and sets status_o bit 3. A push in the same cycle is still accepted.
- R7: status_o bits 3 and 9 stay set until the next xfer_start_i. That pulse clears them, empties the buffer and reloads both word counters and the block counter.
- R8: In card-to-host mode, host_ready_o is 1 when the fill level is nonzero and either reaches the receive threshold or covers all the words the host still has to pop in the current block.
- R9: In host-to-card mode, card_start_o is 1 when the fill level is nonzero and either reaches the transmit threshold or covers all the words the card engine still has to pop in the current block.
- R10: The card side counts its transfers against blk_bytes_i/4 words per block (blk_bytes_i is a nonzero multiple of 4). At each block boundary the block count drops by one. When it reaches zero, status_o bit 9 is set and later card-side transfers are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_start_i | input | 1 | Starts a transfer: latches the direction, loads the counters, flushes the buffer, clears status |
| dir_read_i | input | 1 | Direction sampled at start: 1 = card-to-host, 0 = host-to-card |
| blk_bytes_i | input | 32 | Block size in bytes |
| blk_count_i | input | 9 | Number of blocks |
| rd_thr_i | input | 5 | Receive threshold in words |
| wr_thr_i | input | 5 | Transmit threshold in words |
| host_wr_i | input | 1 | Host write strobe on the data port |
| host_wdata_i | input | 32 | Host write data |
| host_rd_i | input | 1 | Host read strobe on the data port |
| host_rdata_o | output | 32 | Head word, as seen by the host |
| card_push_i | input | 1 | Card engine delivers a word |
| card_wdata_i | input | 32 | Word delivered by the card engine |
| card_pop_i | input | 1 | Card engine takes the head word |
| card_rdata_o | output | 32 | Head word, as seen by the card engine |
| host_ready_o | output | 1 | Host may drain (card-to-host mode) |
| card_start_o | output | 1 | Card engine may send (host-to-card mode) |
| debug_o | output | 32 | Packed fill level and thresholds |
| status_o | output | 11 | Bit 3 buffer error, bit 9 all blocks done |

## Verification
The fill level, the error bit and the completion bit are registered. Each one changes at the clock edge that accepts the strobe. The head data, host_ready_o and card_start_o are decoded from registers without further storage, so they are valid in the same cycle as those registered values. The bench drives every strobe 1 ns after a rising edge and holds it for one period. It samples all results 1 ns after the next rising edge, which is the first point where a one-register result is due, and so never samples at an edge. The vector table advances one cycle per row, so each row's expected values reflect all rows before it.

// File: rtl/sd_fifo_pkg.sv
package sd_fifo_pkg;
  localparam int FIELD_W     = 5;
  localparam int FILL_LSB    = 4;
  localparam int WTHR_LSB    = 9;
  localparam int RTHR_LSB    = 14;
  localparam int DEBUG_W     = 32;
  localparam int STATUS_W    = 11;
  localparam int ST_FIFO_ERR = 3;
  localparam int ST_BLK_DONE = 9;
endpackage

// File: rtl/sd_fifo_mem.sv
module sd_fifo_mem #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [FILL_W-1:0] fill_o,
  output logic              push_ok_o,
  output logic              pop_ok_o,
  output logic              overflow_o,
  output logic              underflow_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [ADDR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [FILL_W-1:0] fill_q;
  logic              full, empty;

  assign full        = (fill_q == FILL_W'(DEPTH));
  assign empty       = (fill_q == '0);
  assign pop_ok_o    = pop_i && !empty;
  assign push_ok_o   = push_i && (!full || pop_ok_o);
  assign overflow_o  = push_i && !push_ok_o;
  assign underflow_o = pop_i && !pop_ok_o;
  assign rdata_o     = mem_q[rd_ptr_q];
  assign fill_o      = fill_q;

  always_ff @(posedge clk_i) begin
    if (push_ok_o && !flush_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      if (push_ok_o) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_ok_o)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({push_ok_o, pop_ok_o})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end
endmodule

// File: rtl/sd_fifo_blk_ctr.sv
module sd_fifo_blk_ctr #(
  parameter int WORD_W       = 30,
  parameter int BLKS_W       = 9,
  parameter bit COUNT_BLOCKS = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] words_i,
  input  logic [BLKS_W-1:0] blocks_i,
  input  logic              step_i,
  output logic [WORD_W-1:0] rem_o,
  output logic              done_o
);
  logic [WORD_W-1:0] wpb_q, rem_q;
  logic              active, wrap;

  assign wrap  = step_i && active && (rem_q == WORD_W'(1));
  assign rem_o = rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wpb_q <= '0;
      rem_q <= '0;
    end else if (load_i) begin
      wpb_q <= words_i;
      rem_q <= words_i;
    end else if (wrap) begin
      rem_q <= wpb_q;
    end else if (step_i && active && rem_q != '0) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  generate
    if (COUNT_BLOCKS) begin : g_blocks
      logic [BLKS_W-1:0] blk_q;
      logic              done_q;
      assign active = (blk_q != '0);
      assign done_o = done_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          blk_q  <= '0;
          done_q <= 1'b0;
        end else if (load_i) begin
          blk_q  <= blocks_i;
          done_q <= 1'b0;
        end else if (wrap) begin
          blk_q <= blk_q - 1'b1;
          if (blk_q == BLKS_W'(1)) done_q <= 1'b1;
        end
      end
    end else begin : g_words_only
      assign active = 1'b1;
      assign done_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/sd_fifo_gate.sv
module sd_fifo_gate #(
  parameter int FILL_W = 5,
  parameter int THR_W  = 5,
  parameter int REM_W  = 30
) (
  input  logic [FILL_W-1:0] fill_i,
  input  logic [THR_W-1:0]  thr_i,
  input  logic [REM_W-1:0]  rem_i,
  output logic              go_o
);
  logic [REM_W-1:0] fill_x, thr_x;
  assign fill_x = REM_W'(fill_i);
  assign thr_x  = REM_W'(thr_i);
  // tail rule lets a short block tail through below threshold
  assign go_o = (fill_i != '0) && ((fill_x >= thr_x) || (fill_x >= rem_i));
endmodule

// File: rtl/sd_data_fifo.sv
module sd_data_fifo
  import sd_fifo_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DATA_W  = 32,
  parameter int BYTES_W = 32,
  parameter int BLKS_W  = 9,
  localparam int FILL_W = $clog2(DEPTH + 1),
  localparam int WORD_W = BYTES_W - 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                xfer_start_i,
  input  logic                dir_read_i,
  input  logic [BYTES_W-1:0]  blk_bytes_i,
  input  logic [BLKS_W-1:0]   blk_count_i,
  input  logic [FIELD_W-1:0]  rd_thr_i,
  input  logic [FIELD_W-1:0]  wr_thr_i,
  input  logic                host_wr_i,
  input  logic [DATA_W-1:0]   host_wdata_i,
  input  logic                host_rd_i,
  output logic [DATA_W-1:0]   host_rdata_o,
  input  logic                card_push_i,
  input  logic [DATA_W-1:0]   card_wdata_i,
  input  logic                card_pop_i,
  output logic [DATA_W-1:0]   card_rdata_o,
  output logic                host_ready_o,
  output logic                card_start_o,
  output logic [DEBUG_W-1:0]  debug_o,
  output logic [STATUS_W-1:0] status_o
);
  logic              dir_q, err_q;
  logic              push, pop, push_ok, pop_ok, ovf, udf;
  logic [DATA_W-1:0] wdata, rdata;
  logic [FILL_W-1:0] fill;
  logic [WORD_W-1:0] words, host_rem, card_rem;
  logic              blk_done, rd_go, wr_go;

  assign push  = dir_q ? card_push_i  : host_wr_i;
  assign wdata = dir_q ? card_wdata_i : host_wdata_i;
  assign pop   = dir_q ? host_rd_i    : card_pop_i;
  assign words = blk_bytes_i[BYTES_W-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= 1'b0;
      err_q <= 1'b0;
    end else if (xfer_start_i) begin
      dir_q <= dir_read_i;
      err_q <= 1'b0;
    end else if (ovf || udf) begin
      err_q <= 1'b1;
    end
  end

  sd_fifo_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
    .clk_i, .rst_ni,
    .flush_i(xfer_start_i), .push_i(push), .pop_i(pop), .wdata_i(wdata),
    .rdata_o(rdata), .fill_o(fill), .push_ok_o(push_ok), .pop_ok_o(pop_ok),
    .overflow_o(ovf), .underflow_o(udf)
  );

  sd_fifo_blk_ctr #(.WORD_W(WORD_W), .BLKS_W(BLKS_W), .COUNT_BLOCKS(1'b0)) u_host_ctr (
    .clk_i, .rst_ni, .load_i(xfer_start_i), .words_i(words), .blocks_i(blk_count_i),
    .step_i(dir_q ? pop_ok : push_ok), .rem_o(host_rem), .done_o()
  );

  sd_fifo_blk_ctr #(.WORD_W(WORD_W), .BLKS_W(BLKS_W), .COUNT_BLOCKS(1'b1)) u_card_ctr (
    .clk_i, .rst_ni, .load_i(xfer_start_i), .words_i(words), .blocks_i(blk_count_i),
    .step_i(dir_q ? push_ok : pop_ok), .rem_o(card_rem), .done_o(blk_done)
  );

  sd_fifo_gate #(.FILL_W(FILL_W), .THR_W(FIELD_W), .REM_W(WORD_W)) u_rd_gate (
    .fill_i(fill), .thr_i(rd_thr_i), .rem_i(host_rem), .go_o(rd_go)
  );

  sd_fifo_gate #(.FILL_W(FILL_W), .THR_W(FIELD_W), .REM_W(WORD_W)) u_wr_gate (
    .fill_i(fill), .thr_i(wr_thr_i), .rem_i(card_rem), .go_o(wr_go)
  );

  assign host_ready_o = dir_q && rd_go;
  assign card_start_o = !dir_q && wr_go;
  assign host_rdata_o = rdata;
  assign card_rdata_o = rdata;

  always_comb begin
    debug_o = '0;
    debug_o[FILL_LSB+:FIELD_W] = FIELD_W'(fill);
    debug_o[WTHR_LSB+:FIELD_W] = wr_thr_i;
    debug_o[RTHR_LSB+:FIELD_W] = rd_thr_i;
    status_o = '0;
    status_o[ST_FIFO_ERR] = err_q;
    status_o[ST_BLK_DONE] = blk_done;
  end
endmodule

// File: rtl/sd_data_fifo_chk.sv
module sd_data_fifo_chk
  import sd_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int FILL_W = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                xfer_start_i,
  input logic                dir_q,
  input logic [FILL_W-1:0]   fill,
  input logic                host_wr_i,
  input logic                host_rd_i,
  input logic                card_pop_i,
  input logic                host_ready_o,
  input logic                card_start_o,
  input logic [STATUS_W-1:0] status_o
);
  a_r3_fill_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(fill) <= DEPTH);

  a_r3_fill_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_start_i |=> (int'(fill) <= int'($past(fill)) + 1) && (int'(fill) + 1 >= int'($past(fill))));

  a_r5_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_start_i && !dir_q && host_wr_i && !card_pop_i && int'(fill) == DEPTH) |=> status_o[ST_FIFO_ERR]);

  a_r6_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_start_i && fill == '0 && (dir_q ? host_rd_i : card_pop_i)) |=> status_o[ST_FIFO_ERR]);

  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[ST_FIFO_ERR] && !xfer_start_i) |=> status_o[ST_FIFO_ERR]);

  a_r10_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[ST_BLK_DONE] && !xfer_start_i) |=> status_o[ST_BLK_DONE]);

  a_r8_r9_gates_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_ready_o && card_start_o));

  a_r8_empty_no_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill == '0) |-> (!host_ready_o && !card_start_o));
endmodule

bind sd_data_fifo sd_data_fifo_chk #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .xfer_start_i(xfer_start_i), .dir_q(dir_q),
  .fill(fill), .host_wr_i(host_wr_i), .host_rd_i(host_rd_i), .card_pop_i(card_pop_i),
  .host_ready_o(host_ready_o), .card_start_o(card_start_o), .status_o(status_o)
);

// File: tb/sd_data_fifo_tb.sv
module sd_data_fifo_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        xfer_start_i = 1'b0, dir_read_i = 1'b0;
  logic [31:0] blk_bytes_i = '0;
  logic [8:0]  blk_count_i = '0;
  logic [4:0]  rd_thr_i = '0, wr_thr_i = '0;
  logic        host_wr_i = 1'b0, host_rd_i = 1'b0, card_push_i = 1'b0, card_pop_i = 1'b0;
  logic [31:0] host_wdata_i = '0, card_wdata_i = '0;
  logic [31:0] host_rdata_o, card_rdata_o, debug_o;
  logic        host_ready_o, card_start_o;
  logic [10:0] status_o;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  sd_data_fifo u_dut (.*);

  // row: [9] card push, [8] host read, [7:3] fill, [2] host_ready, [1] err, [0] done
  localparam int NV = 13;
  localparam logic [9:0] VEC [NV] = '{
    {1'b1, 1'b0, 5'd1, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 5'd2, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 5'd3, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b1, 5'd2, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 5'd3, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b1, 5'd2, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b1, 5'd1, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b1, 5'd1, 1'b0, 1'b1, 1'b0},
    {1'b1, 1'b0, 5'd2, 1'b0, 1'b1, 1'b0},
    {1'b1, 1'b0, 5'd3, 1'b1, 1'b1, 1'b0},
    {1'b1, 1'b0, 5'd4, 1'b1, 1'b1, 1'b1},
    {1'b1, 1'b0, 5'd5, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
    xfer_start_i = 1'b0;
    host_wr_i = 1'b0; host_rd_i = 1'b0; card_push_i = 1'b0; card_pop_i = 1'b0;
  endtask

  task automatic start(input logic rd, input logic [31:0] bytes, input logic [8:0] cnt);
    dir_read_i = rd; blk_bytes_i = bytes; blk_count_i = cnt; xfer_start_i = 1'b1;
    tick();
  endtask

  task automatic hwrite(input logic [31:0] d);
    host_wr_i = 1'b1; host_wdata_i = d;
    tick();
  endtask

  task automatic cpop();
    card_pop_i = 1'b1;
    tick();
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1 reset state
    chk("R1 fill", {27'd0, debug_o[8:4]}, 32'd0);
    chk("R1 status", {21'd0, status_o}, 32'd0);
    chk("R1 gates", {30'd0, host_ready_o, card_start_o}, 32'd0);

    // R2 debug packing
    rd_thr_i = 5'd3; wr_thr_i = 5'd5; #1;
    chk("R2 debug", debug_o, (32'd5 << 9) | (32'd3 << 14));

    // table: card-to-host, 4-word blocks, 2 blocks, rx threshold 3 (R3 R6 R8 R10)
    start(1'b1, 32'd16, 9'd2);
    for (int i = 0; i < NV; i++) begin
      card_push_i = VEC[i][9];
      host_rd_i   = VEC[i][8];
      card_wdata_i = 32'hC0DE_0000 + 32'(i);
      tick();
      chk($sformatf("R3 fill row %0d", i), {27'd0, debug_o[8:4]}, {27'd0, VEC[i][7:3]});
      chk($sformatf("R8 ready row %0d", i), {31'd0, host_ready_o}, {31'd0, VEC[i][2]});
      chk($sformatf("R6 err row %0d", i), {31'd0, status_o[3]}, {31'd0, VEC[i][1]});
      chk($sformatf("R10 done row %0d", i), {31'd0, status_o[9]}, {31'd0, VEC[i][0]});
    end
    chk("R3 order head", host_rdata_o, 32'hC0DE_0008);
    host_rd_i = 1'b1; tick();
    chk("R3 order next", host_rdata_o, 32'hC0DE_0009);
    chk("R9 no card_start in rx mode", {31'd0, card_start_o}, 32'd0);

    // R7 start clears error and done, flushes
    start(1'b0, 32'd256, 9'd1);
    chk("R7 cleared", {21'd0, status_o}, 32'd0);
    chk("R7 flushed", {27'd0, debug_o[8:4]}, 32'd0);

    // R4 unused strobes ignored in host-to-card mode
    card_push_i = 1'b1; host_rd_i = 1'b1; card_wdata_i = 32'hDEAD_BEEF;
    tick();
    chk("R4 fill", {27'd0, debug_o[8:4]}, 32'd0);
    chk("R4 err", {31'd0, status_o[3]}, 32'd0);

    // R5 overflow
    for (int i = 0; i < 17; i++) hwrite(32'h100 + 32'(i));
    chk("R5 fill", {27'd0, debug_o[8:4]}, 32'd16);
    chk("R5 err", {31'd0, status_o[3]}, 32'd1);
    chk("R5 head kept", card_rdata_o, 32'h100);
    // simultaneous push and pop when full is not an overflow
    start(1'b0, 32'd256, 9'd1);
    for (int i = 0; i < 16; i++) hwrite(32'h200 + 32'(i));
    host_wr_i = 1'b1; host_wdata_i = 32'h2FF; card_pop_i = 1'b1; tick();
    chk("R5 full push+pop err", {31'd0, status_o[3]}, 32'd0);
    chk("R5 full push+pop head", card_rdata_o, 32'h201);

    // R9 transmit gate: 3-word blocks, threshold 8 -> tail rule
    wr_thr_i = 5'd8;
    start(1'b0, 32'd12, 9'd2);
    hwrite(32'h1); hwrite(32'h2);
    chk("R9 below", {31'd0, card_start_o}, 32'd0);
    hwrite(32'h3);
    chk("R9 tail", {31'd0, card_start_o}, 32'd1);
    chk("R8 no host_ready in tx mode", {31'd0, host_ready_o}, 32'd0);
    cpop(); cpop(); cpop();
    chk("R9 empty", {31'd0, card_start_o}, 32'd0);
    chk("R10 first block not done", {31'd0, status_o[9]}, 32'd0);
    wr_thr_i = 5'd2;
    hwrite(32'h4);
    chk("R9 one below thr", {31'd0, card_start_o}, 32'd0);
    hwrite(32'h5);
    chk("R9 at thr", {31'd0, card_start_o}, 32'd1);
    hwrite(32'h6);
    cpop(); cpop();
    chk("R10 before last", {31'd0, status_o[9]}, 32'd0);
    cpop();
    chk("R10 done", {31'd0, status_o[9]}, 32'd1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule